// File: doc/BRIEF.md
# Nibble-Serial Program Counter Stack

This block keeps four 12-bit program addresses in a small row array. One row at a time is the live instruction address, and a 2-bit row pointer selects it. A subroutine call moves the pointer up one row and fills the new row with the call target. A return moves the pointer down one row, so the address saved before the call becomes live again. The stack is circular: the pointer wraps modulo four, and nothing flags an overflow or an underflow.

The block has its own incrementer and does not use an arithmetic unit to advance the address. The incrementer handles the 12-bit address as three 4-bit nibbles, least significant nibble first, one nibble per clock. A carry register passes the carry from each nibble to the next, and the carry out of the top nibble is dropped. Storage is read and written one nibble column at a time. A 3:1 read selector and a separate 3:1 write selector pick the column. A free-running refresh counter visits one row per cycle and rewrites that row with its own contents whenever no incrementer or call write is going to the same row.

Control is a three-state machine. IDLE accepts commands. INCR writes the incremented nibbles. LOAD writes the call target nibbles. The transitions are: IDLE to LOAD on an accepted call, IDLE to INCR on an accepted step, IDLE to IDLE on an accepted return or when no command is present, INCR to INCR and LOAD to LOAD while the column counter is below 2, and INCR or LOAD back to IDLE after column 2 has been written.

Top module: `pcstk_top`

## Requirements
- R1: After reset every row holds 0, the pointer selects row 0, and addr_o and nib_o are both 0.
- R2: A step strobe accepted in IDLE replaces the active row with its value plus one. The new value is on addr_o after the third write edge that follows the accepting edge, and the block is in IDLE again at that point.
- R3: A carry out of a nibble is added into the next nibble: 0x0FF steps to 0x100, and 0xFFF steps to 0x000 (modulo 4096).
- R4: A call accepted in IDLE increments the pointer modulo 4 on the accepting edge. It then writes tgt_i into the new row, nibble 0 (bits 3:0) first, then bits 7:4, then bits 11:8, one nibble per edge.
- R5: A return accepted in IDLE decrements the pointer modulo 4 on the accepting edge. From the next cycle on, addr_o shows the contents of the row now selected.
- R6: After three nested calls followed by three returns, addr_o shows the address that was live before the first call. Each return in between shows the row the matching call left behind.
- R7: The pointer wraps. Four calls from row 0 land on row 0 again and overwrite it, and a return from row 0 selects row 3.
- R8: While INCR or LOAD is in progress, step_i, call_i and ret_i are ignored. The pointer and the operation in progress are unchanged.
- R9: When several commands arrive together in IDLE, call wins over return, and return wins over step.
- R10: In IDLE, nib_o equals addr_o[3:0]. During INCR, nib_o shows the not yet rewritten nibble of the column being processed: bits 3:0 in the first cycle, bits 7:4 in the second.
- R11: The refresh counter advances one row per clock and wraps modulo 4. Refresh never changes stored contents, so rows keep their values through long idle periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Advance the live address by one |
| call_i | input | 1 | Push: move the pointer up and load tgt_i |
| ret_i | input | 1 | Pop: move the pointer down |
| tgt_i | input | 12 | Call target, sampled one nibble per LOAD cycle |
| nib_o | output | 4 | Nibble of the live row at the current read column |
| addr_o | output | 12 | Full live address |

## Verification
The properties assume that commands matter only in IDLE, and that tgt_i holds steady for the three LOAD cycles after a call is accepted. The stimulus holds each command for exactly one clock. It keeps tgt_i constant until the call completes and waits one settled idle cycle between operations. It also drives commands during busy cycles on purpose, to show they are dropped, and drives simultaneous commands to exercise the priority order.

// File: rtl/pcstk_pkg.sv
package pcstk_pkg;
    // control states of the nibble sequencer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INCR = 2'd1,
        ST_LOAD = 2'd2
    } pcstk_state_e;
endpackage

// File: rtl/pcstk_array.sv
// Row storage built from per-nibble cells, with 3:1 column read/write select.
module pcstk_array #(
    parameter int NIB_W  = 4,
    parameter int NIBS   = 3,
    parameter int DEPTH  = 4,
    localparam int ADDR_W = NIB_W * NIBS,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int COL_W  = $clog2(NIBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_row,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [NIB_W-1:0]  wr_nib,
    input  logic [PTR_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    input  logic [PTR_W-1:0]  ref_row,
    output logic [ADDR_W-1:0] rd_word,
    output logic [NIB_W-1:0]  rd_nib
);
    logic [DEPTH-1:0][NIBS-1:0][NIB_W-1:0] cells;

    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        logic row_wr;
        logic row_ref;
        assign row_wr  = wr_en && (wr_row == PTR_W'(r));
        assign row_ref = (ref_row == PTR_W'(r)) && !row_wr;
        for (genvar c = 0; c < NIBS; c++) begin : g_col
            logic [NIB_W-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cell_q <= '0;
                end else if (row_wr && (wr_col == COL_W'(c))) begin
                    cell_q <= wr_nib;
                end else if (row_ref) begin
                    cell_q <= cell_q;   // refresh rewrite
                end
            end
            assign cells[r][c] = cell_q;
        end
    end

    always_comb begin
        rd_word = cells[rd_row];
        rd_nib  = '0;
        for (int c = 0; c < NIBS; c++) begin
            if (rd_col == COL_W'(c)) rd_nib = cells[rd_row][c];
        end
    end
endmodule

// File: rtl/pcstk_incr.sv
// One-nibble incrementer slice with carry in and carry out.
module pcstk_incr #(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0] nib_in,
    input  logic             cin,
    output logic [NIB_W-1:0] nib_out,
    output logic             cout
);
    always_comb begin
        {cout, nib_out} = {1'b0, nib_in} + {{NIB_W{1'b0}}, cin};
    end
endmodule

// File: rtl/pcstk_ptr.sv
// Circular row pointer; DEPTH is expected to be a power of two.
module pcstk_ptr #(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    input  logic             down,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (up)    ptr <= ptr + 1'b1;
        else if (down)  ptr <= ptr - 1'b1;
    end
endmodule

// File: rtl/pcstk_refresh.sv
// Free-running row visitor for background rewrite.
module pcstk_refresh #(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PTR_W-1:0] ref_row
);
    always_ff @(posedge clk) begin
        if (!rst_n) ref_row <= '0;
        else        ref_row <= ref_row + 1'b1;
    end
endmodule

// File: rtl/pcstk_top.sv
module pcstk_top
    import pcstk_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int NIBS  = 3,
    parameter int DEPTH = 4,
    localparam int ADDR_W = NIB_W * NIBS,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int COL_W  = $clog2(NIBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [ADDR_W-1:0] tgt_i,
    output logic [NIB_W-1:0]  nib_o,
    output logic [ADDR_W-1:0] addr_o
);
    pcstk_state_e     state_q, state_d;
    logic [COL_W-1:0] col_q, col_d;
    logic             carry_q, carry_d;
    logic [PTR_W-1:0] ea_q;
    logic [PTR_W-1:0] ref_row;

    logic             idle, last_col;
    logic             take_call, take_ret, take_step;
    logic [NIB_W-1:0] rd_nib, sum_nib, tgt_nib, wr_nib;
    logic             sum_cout, wr_en;

    assign idle      = (state_q == ST_IDLE);
    assign last_col  = (col_q == COL_W'(NIBS - 1));
    assign take_call = idle && call_i;
    assign take_ret  = idle && ret_i && !call_i;
    assign take_step = idle && step_i && !call_i && !ret_i;

    // next-state and sequencing counters
    always_comb begin
        state_d = state_q;
        col_d   = col_q;
        carry_d = carry_q;
        unique case (state_q)
            ST_IDLE: begin
                col_d = '0;
                if (take_call) begin
                    state_d = ST_LOAD;
                end else if (take_step) begin
                    state_d = ST_INCR;
                    carry_d = 1'b1;
                end
            end
            ST_INCR: begin
                carry_d = sum_cout;
                if (last_col) begin
                    state_d = ST_IDLE;
                    col_d   = '0;
                end else begin
                    col_d = col_q + 1'b1;
                end
            end
            ST_LOAD: begin
                if (last_col) begin
                    state_d = ST_IDLE;
                    col_d   = '0;
                end else begin
                    col_d = col_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                col_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            carry_q <= carry_d;
        end
    end

    // outputs toward the storage write port
    always_comb begin
        tgt_nib = '0;
        for (int c = 0; c < NIBS; c++) begin
            if (col_q == COL_W'(c)) tgt_nib = tgt_i[c*NIB_W +: NIB_W];
        end
        unique case (state_q)
            ST_INCR: begin wr_en = 1'b1; wr_nib = sum_nib; end
            ST_LOAD: begin wr_en = 1'b1; wr_nib = tgt_nib; end
            default: begin wr_en = 1'b0; wr_nib = '0;      end
        endcase
    end

    pcstk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .up   (take_call),
        .down (take_ret),
        .ptr  (ea_q)
    );

    pcstk_refresh #(.DEPTH(DEPTH)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_row(ref_row)
    );

    pcstk_incr #(.NIB_W(NIB_W)) u_incr (
        .nib_in (rd_nib),
        .cin    (carry_q),
        .nib_out(sum_nib),
        .cout   (sum_cout)
    );

    pcstk_array #(.NIB_W(NIB_W), .NIBS(NIBS), .DEPTH(DEPTH)) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_row (ea_q),
        .wr_col (col_q),
        .wr_nib (wr_nib),
        .rd_row (ea_q),
        .rd_col (col_q),
        .ref_row(ref_row),
        .rd_word(addr_o),
        .rd_nib (rd_nib)
    );

    assign nib_o = rd_nib;
endmodule

// File: rtl/pcstk_chk.sv
module pcstk_chk
    import pcstk_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int NIBS  = 3,
    parameter int DEPTH = 4,
    localparam int ADDR_W = NIB_W * NIBS,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int COL_W  = $clog2(NIBS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_i,
    input logic              call_i,
    input logic              ret_i,
    input logic [1:0]        st,
    input logic [COL_W-1:0]  col,
    input logic [PTR_W-1:0]  ea,
    input logic [PTR_W-1:0]  ref_row,
    input logic [NIB_W-1:0]  nib_o,
    input logic [ADDR_W-1:0] addr_o
);
    logic is_idle;
    assign is_idle = (st == ST_IDLE);

    p_call_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && call_i) |=> (ea == PTR_W'($past(ea) + 1'b1)) && (st == ST_LOAD));

    p_ret_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && ret_i && !call_i) |=> (ea == PTR_W'($past(ea) - 1'b1)) && (st == ST_IDLE));

    p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_idle |=> $stable(ea));

    p_step_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && step_i && !call_i && !ret_i) |=> (st == ST_INCR) && $stable(ea));

    p_three_nibbles_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_idle && col == COL_W'(NIBS - 1)) |=> is_idle);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && !step_i && !call_i && !ret_i) |=> $stable(addr_o));

    p_refresh_walk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ref_row == PTR_W'($past(ref_row) + 1'b1));

    p_idle_low_nib_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |-> nib_o == addr_o[NIB_W-1:0]);
endmodule

bind pcstk_top pcstk_chk #(.NIB_W(NIB_W), .NIBS(NIBS), .DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .st     (state_q),
    .col    (col_q),
    .ea     (ea_q),
    .ref_row(ref_row),
    .nib_o  (nib_o),
    .addr_o (addr_o)
);

// File: tb/pcstk_top_test.sv
module pcstk_top_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        call_i = 1'b0;
    logic        ret_i = 1'b0;
    logic [11:0] tgt_i = '0;
    logic [3:0]  nib_o;
    logic [11:0] addr_o;

    pcstk_top uut (
        .clk   (clk),
        .rst_n (rst_n),
        .step_i(step_i),
        .call_i(call_i),
        .ret_i (ret_i),
        .tgt_i (tgt_i),
        .nib_o (nib_o),
        .addr_o(addr_o)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        string       req;
        logic [11:0] exp;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [11:0] m [4];
    int          ea = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push(string req, logic [11:0] exp);
        exp_t it;
        it.req = req;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    // monitor: compares queued expectations a quarter period after an edge
    always @(posedge clk) begin
        #(CLK_P/4);
        while (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            chk(it.req, int'(addr_o), int'(it.exp));
            chk({it.req, " R10 idle nibble"}, int'(nib_o), int'(it.exp[3:0]));
        end
    end

    task automatic do_step(string req);
        logic [11:0] old;
        old = m[ea];
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        chk("R10 first busy nibble", int'(nib_o), int'(old[3:0]));
        @(negedge clk);
        chk("R10 second busy nibble", int'(nib_o), int'(old[7:4]));
        repeat (2) @(negedge clk);
        m[ea] = old + 12'd1;
        push(req, m[ea]);
        @(negedge clk);
    endtask

    task automatic do_call(string req, logic [11:0] t);
        tgt_i = t;
        call_i = 1'b1;
        @(negedge clk);
        call_i = 1'b0;
        repeat (3) @(negedge clk);
        ea = (ea + 1) % 4;
        m[ea] = t;
        push(req, m[ea]);
        @(negedge clk);
    endtask

    task automatic do_ret(string req);
        ret_i = 1'b1;
        @(negedge clk);
        ret_i = 1'b0;
        ea = (ea + 3) % 4;
        push(req, m[ea]);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset addr", int'(addr_o), 0);
        chk("R1 reset nibble", int'(nib_o), 0);

        do_step("R2 step from zero");
        do_step("R2 second step");

        do_call("R4 call to 0x0FF", 12'h0FF);
        do_step("R3 carry 0x0FF to 0x100");
        do_call("R4 call to 0xFFF", 12'hFFF);
        do_step("R3 wrap 0xFFF to 0x000");
        do_call("R4 call to 0x234", 12'h234);
        do_ret("R5 return to row 2");
        do_ret("R5 return to row 1");
        do_ret("R5 return to row 0");

        repeat (60) @(negedge clk);
        push("R11 row kept over idle", m[ea]);
        @(negedge clk);

        do_call("R6 nested call 1", 12'hA11);
        do_call("R6 nested call 2", 12'hB22);
        do_call("R6 nested call 3", 12'hC33);
        do_ret("R6 return 1");
        do_ret("R6 return 2");
        do_ret("R6 return 3 restores origin");

        do_call("R7 call a", 12'h101);
        do_call("R7 call b", 12'h202);
        do_call("R7 call c", 12'h303);
        do_call("R7 fourth call overwrites row 0", 12'h404);
        do_ret("R7 return to row 3");
        do_ret("R7 return to row 2");
        do_ret("R7 return to row 1");
        do_ret("R7 return to row 0");
        do_ret("R7 return from row 0 wraps to row 3");

        // R8: commands during the increment are dropped
        begin
            logic [11:0] old;
            old = m[ea];
            step_i = 1'b1;
            @(negedge clk);
            step_i = 1'b0;
            call_i = 1'b1;
            ret_i = 1'b1;
            tgt_i = 12'h777;
            @(negedge clk);
            call_i = 1'b0;
            ret_i = 1'b0;
            step_i = 1'b1;
            @(negedge clk);
            step_i = 1'b0;
            @(negedge clk);
            m[ea] = old + 12'd1;
            push("R8 busy commands ignored", m[ea]);
            @(negedge clk);
            chk("R8 no extra step", int'(addr_o), int'(m[ea]));
        end
        do_ret("R8 pointer untouched by busy commands");

        // R9: call beats return and step
        tgt_i = 12'h5A5;
        call_i = 1'b1;
        ret_i = 1'b1;
        step_i = 1'b1;
        @(negedge clk);
        call_i = 1'b0;
        ret_i = 1'b0;
        step_i = 1'b0;
        repeat (3) @(negedge clk);
        ea = (ea + 1) % 4;
        m[ea] = 12'h5A5;
        push("R9 call has priority", m[ea]);
        @(negedge clk);

        // R9: return beats step
        ret_i = 1'b1;
        step_i = 1'b1;
        @(negedge clk);
        ret_i = 1'b0;
        step_i = 1'b0;
        ea = (ea + 3) % 4;
        push("R9 return over step", m[ea]);
        repeat (4) @(negedge clk);
        chk("R9 no step after return", int'(addr_o), int'(m[ea]));

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule